// File: doc/BRIEF.md
# Boot-Region Remap and Bridge Gating Decoder

This block is the address decoder in front of an SoC interconnect. Every request carries an address, a valid strobe and a flag that says whether it comes from a processor or from another master (DMA engines, debug, the fabric). The decoder picks one target in the same cycle: the boot ROM, the on-chip RAM, SDRAM, the high-speed fabric bridge window, the lightweight fabric bridge window, or the remaining interconnect space. When a request must not reach any target, it raises a decode-error flag instead, which the interconnect turns into a decode-error response.

What answers at address zero depends on the master class and on a small control word. Processors see either the boot ROM or the on-chip RAM there. Other masters see either SDRAM or the on-chip RAM. Both small memories are 64 KB. Each one also keeps a permanent alias near the top of the address space that does not move with the remap. Each fabric bridge window is gated by its own enable bit. The control word can only be written: every write replaces all of it, and its read port always returns zero.

Top module: `boot_remap_decoder`

## Requirements
- R1: After a synchronous reset the control word is 0. Processors then see the boot ROM at zero, other masters see SDRAM at zero, and both bridge windows return a decode error.
- R2: For a processor address below 0x0001_0000, the target is the boot ROM when control bit 0 is 0 and the on-chip RAM when it is 1.
- R3: For a processor address from 0x0001_0000 to 0x000F_FFFF, the decoder raises the decode error whatever the control word holds.
- R4: For a non-processor address below 0x0010_0000, the target is SDRAM when control bit 1 is 0. When bit 1 is 1, addresses below 0x0001_0000 go to the on-chip RAM and the rest of that range goes to SDRAM.
- R5: Addresses from 0x0010_0000 to 0xBFFF_FFFF go to SDRAM for both master classes.
- R6: Addresses from 0xC000_0000 to 0xFBFF_FFFF go to the high-speed bridge when control bit 2 is 1. When bit 2 is 0 they raise the decode error.
- R7: Addresses from 0xFF20_0000 to 0xFF3F_FFFF go to the lightweight bridge when control bit 3 is 1. When bit 3 is 0 they raise the decode error.
- R8: Addresses from 0xFFFD_0000 to 0xFFFD_FFFF go to the boot ROM for processors whatever the control word holds. For other masters they go to the interconnect space.
- R9: Addresses from 0xFFFF_0000 to 0xFFFF_FFFF go to the on-chip RAM for all masters whatever the control word holds.
- R10: Every other address goes to the interconnect space.
- R11: The target select is one-hot: bit 0 is boot ROM, bit 1 on-chip RAM, bit 2 SDRAM, bit 3 high-speed bridge, bit 4 lightweight bridge, bit 5 interconnect space. Exactly one bit is set for a valid request without an error. The select is zero while the decode error is raised. While valid is low, the select is zero and the decode error is low.
- R12: The control port can only be written. A write replaces the whole word and takes effect from the clock edge that samples it. The read-data output is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | New control word: bit 0 processor zero target, bit 1 non-processor zero target, bit 2 high-speed bridge enable, bit 3 lightweight bridge enable |
| cfg_rdata | output | 4 | Control read data, always zero |
| req_valid | input | 1 | Request address is valid |
| req_cpu | input | 1 | 1 = processor master, 0 = other master |
| req_addr | input | 32 | Request byte address |
| tgt_sel | output | 6 | One-hot target select |
| dec_err | output | 1 | Decode error for this request |

## Verification
The hardest cases are the ones where the result depends on three things at once: the master class, the address window and the current control word. Examples are the processor hole just above 64 KB, the ROM alias seen by each master class, and a bridge window just after its enable bit was cleared by a full-word write. The stimulus steps through all sixteen control words. Under each one it drives both master classes against a list of addresses placed on and next to every window edge. A random phase follows, with random writes mixed into the requests so that a request lands in the same cycle as a write. A behavioural model in the bench is compared against the design on every clock.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int CFG_W = 4;
  localparam int TGT_N = 6;

  // one-hot target select bit positions (R11)
  localparam int TGT_ROM   = 0;
  localparam int TGT_RAM   = 1;
  localparam int TGT_SDRAM = 2;
  localparam int TGT_H2F   = 3;
  localparam int TGT_LW    = 4;
  localparam int TGT_OTHER = 5;

  // address window indices
  localparam int W_LOW_SMALL  = 0;
  localparam int W_LOW_REGION = 1;
  localparam int W_SDRAM      = 2;
  localparam int W_H2F        = 3;
  localparam int W_LW         = 4;
  localparam int W_ROM_ALIAS  = 5;
  localparam int W_RAM_ALIAS  = 6;
  localparam int NWIN         = 7;

  typedef struct packed {
    logic lw_en;         // bit 3
    logic h2f_en;        // bit 2
    logic dev_zero_ram;  // bit 1
    logic cpu_zero_ram;  // bit 0
  } remap_cfg_t;
endpackage

// File: rtl/remap_ctrl_reg.sv
module remap_ctrl_reg
  import remap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output remap_cfg_t       cfg
);
  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else if (wr_en) cfg <= remap_cfg_t'(wr_data);
  end

  // R12: a write replaces every bit of the word
  a_r12_full_replace: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cfg == $past(wr_data)));
  // R12: without a write the word holds
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg));
endmodule

// File: rtl/remap_window.sv
module remap_window #(
  parameter int               ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LO    = '0,
  parameter logic [ADDR_W-1:0] HI    = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  generate
    if (LO == '0) begin : g_from_zero
      assign hit = (addr <= HI);
    end else begin : g_bounded
      assign hit = (addr >= LO) && (addr <= HI);
    end
  endgenerate
endmodule

// File: rtl/remap_route.sv
module remap_route
  import remap_pkg::*;
(
  input  logic             valid,
  input  logic             cpu,
  input  logic [NWIN-1:0]  hit,
  input  remap_cfg_t       cfg,
  output logic [TGT_N-1:0] sel,
  output logic             err
);
  int  pick;
  logic bad;

  always_comb begin
    pick = TGT_OTHER;
    bad  = 1'b0;
    if (hit[W_LOW_REGION]) begin
      if (cpu) begin
        if (hit[W_LOW_SMALL]) pick = cfg.cpu_zero_ram ? TGT_RAM : TGT_ROM;
        else bad = 1'b1;
      end else begin
        pick = (cfg.dev_zero_ram && hit[W_LOW_SMALL]) ? TGT_RAM : TGT_SDRAM;
      end
    end else if (hit[W_SDRAM]) begin
      pick = TGT_SDRAM;
    end else if (hit[W_H2F]) begin
      pick = TGT_H2F;
      bad  = !cfg.h2f_en;
    end else if (hit[W_LW]) begin
      pick = TGT_LW;
      bad  = !cfg.lw_en;
    end else if (hit[W_ROM_ALIAS]) begin
      pick = cpu ? TGT_ROM : TGT_OTHER;
    end else if (hit[W_RAM_ALIAS]) begin
      pick = TGT_RAM;
    end
    err = valid && bad;
    sel = (valid && !bad) ? (TGT_N'(1) << pick) : '0;
  end
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import remap_pkg::*;
#(
  parameter int                ADDR_W         = 32,
  parameter logic [ADDR_W-1:0] SMALL_BYTES    = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] REGION_BYTES   = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] SDRAM_END      = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] H2F_BASE       = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] H2F_LAST       = 32'hFBFF_FFFF,
  parameter logic [ADDR_W-1:0] LW_BASE        = 32'hFF20_0000,
  parameter logic [ADDR_W-1:0] LW_LAST        = 32'hFF3F_FFFF,
  parameter logic [ADDR_W-1:0] ROM_ALIAS_BASE = 32'hFFFD_0000,
  parameter logic [ADDR_W-1:0] RAM_ALIAS_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic              req_cpu,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [TGT_N-1:0]  tgt_sel,
  output logic              dec_err
);
  localparam logic [ADDR_W-1:0] ZERO = {ADDR_W{1'b0}};
  localparam logic [ADDR_W-1:0] ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] SMALL_LAST     = SMALL_BYTES - ONE;
  localparam logic [ADDR_W-1:0] REGION_LAST    = REGION_BYTES - ONE;
  localparam logic [ADDR_W-1:0] SDRAM_LAST     = SDRAM_END - ONE;
  localparam logic [ADDR_W-1:0] ROM_ALIAS_LAST = ROM_ALIAS_BASE + SMALL_LAST;
  localparam logic [ADDR_W-1:0] RAM_ALIAS_LAST = RAM_ALIAS_BASE + SMALL_LAST;

  localparam logic [NWIN-1:0][ADDR_W-1:0] WIN_LO =
    {RAM_ALIAS_BASE, ROM_ALIAS_BASE, LW_BASE, H2F_BASE, REGION_BYTES, ZERO, ZERO};
  localparam logic [NWIN-1:0][ADDR_W-1:0] WIN_HI =
    {RAM_ALIAS_LAST, ROM_ALIAS_LAST, LW_LAST, H2F_LAST, SDRAM_LAST, REGION_LAST, SMALL_LAST};

  remap_cfg_t      cfg;
  logic [NWIN-1:0] hit;

  remap_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr),
    .wr_data (cfg_wdata),
    .cfg     (cfg)
  );

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      remap_window #(.ADDR_W(ADDR_W), .LO(WIN_LO[w]), .HI(WIN_HI[w])) u_win (
        .addr (req_addr),
        .hit  (hit[w])
      );
    end
  endgenerate

  remap_route u_route (
    .valid (req_valid),
    .cpu   (req_cpu),
    .hit   (hit),
    .cfg   (cfg),
    .sel   (tgt_sel),
    .err   (dec_err)
  );

  assign cfg_rdata = '0;  // R12: write-only word

  a_r11_single_target: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !dec_err) |-> ($countones(tgt_sel) == 1));
  a_r11_err_no_target: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> (tgt_sel == '0));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (tgt_sel == '0 && !dec_err));
  a_r9_ram_alias: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit[W_RAM_ALIAS]) |-> tgt_sel[TGT_RAM]);
  a_r3_cpu_hole: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cpu && hit[W_LOW_REGION] && !hit[W_LOW_SMALL]) |-> dec_err);
  a_r6_h2f_gate: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit[W_H2F] && !cfg.h2f_en) |-> dec_err);
  a_r7_lw_gate: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit[W_LW] && !cfg.lw_en) |-> dec_err);
endmodule

// File: tb/boot_remap_decoder_test.sv
module boot_remap_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic [3:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_cpu = 1'b0;
  logic [31:0] req_addr = '0;
  logic [5:0]  tgt_sel;
  logic        dec_err;

  int checks = 0;
  int fails  = 0;
  bit run = 0;
  bit ever_written = 0;
  bit just_wrote = 0;
  bit finished = 0;
  logic [3:0] mcfg = '0;

  localparam logic [31:0] PTS [20] = '{
    32'h0000_0000, 32'h0000_FFFF, 32'h0001_0000, 32'h000F_FFFF, 32'h0010_0000,
    32'hBFFF_FFFF, 32'hC000_0000, 32'hFBFF_FFFF, 32'hFC00_0000, 32'hFF1F_FFFF,
    32'hFF20_0000, 32'hFF3F_FFFF, 32'hFF40_0000, 32'hFFFC_FFFF, 32'hFFFD_0000,
    32'hFFFD_FFFF, 32'hFFFE_0000, 32'hFFFE_FFFF, 32'hFFFF_0000, 32'hFFFF_FFFF};

  boot_remap_decoder uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_cpu(req_cpu), .req_addr(req_addr),
    .tgt_sel(tgt_sel), .dec_err(dec_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference taken from the requirements
  task automatic ref_model(input logic v, input logic c, input logic [31:0] a,
                           input logic [3:0] cf, output logic [5:0] s,
                           output logic e, output string tag);
    int t;
    t = 5; e = 1'b0;
    if (!v) begin
      tag = "R11"; s = '0; return;
    end
    if (c && a < 32'h0001_0000) begin
      tag = "R2"; t = cf[0] ? 1 : 0;
    end else if (c && a < 32'h0010_0000) begin
      tag = "R3"; e = 1'b1;
    end else if (a < 32'h0010_0000) begin
      tag = "R4"; t = (cf[1] && a < 32'h0001_0000) ? 1 : 2;
    end else if (a < 32'hC000_0000) begin
      tag = "R5"; t = 2;
    end else if (a <= 32'hFBFF_FFFF) begin
      tag = "R6"; t = 3; e = !cf[2];
    end else if (a >= 32'hFF20_0000 && a <= 32'hFF3F_FFFF) begin
      tag = "R7"; t = 4; e = !cf[3];
    end else if (a >= 32'hFFFD_0000 && a <= 32'hFFFD_FFFF) begin
      tag = "R8"; t = c ? 0 : 5;
    end else if (a >= 32'hFFFF_0000) begin
      tag = "R9"; t = 1;
    end else begin
      tag = "R10"; t = 5;
    end
    s = e ? 6'b0 : (6'b1 << t);
  endtask

  always @(negedge clk) begin
    if (run) begin
      logic [5:0] es;
      logic ee;
      string tag;
      ref_model(req_valid, req_cpu, req_addr, mcfg, es, ee, tag);
      if (!ever_written) tag = {"R1/", tag};
      if (just_wrote) tag = {"R12/", tag};
      just_wrote = 0;
      checks++;
      if (tgt_sel !== es || dec_err !== ee) begin
        fails++;
        $display("FAIL %s cpu=%b addr=%h cfg=%b: sel=%b err=%b expected sel=%b err=%b",
                 tag, req_cpu, req_addr, mcfg, tgt_sel, dec_err, es, ee);
      end
      checks++;
      if (cfg_rdata !== 4'b0) begin
        fails++;
        $display("FAIL R12 read data %b expected 0000", cfg_rdata);
      end
    end
  end

  task automatic drive(input logic v, input logic c, input logic [31:0] a);
    @(posedge clk); #1;
    req_valid = v; req_cpu = c; req_addr = a;
  endtask

  task automatic cfg_write(input logic [3:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0; mcfg = d; ever_written = 1; just_wrote = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0; run = 1;
    // R1: reset defaults seen through the decode
    drive(1, 1, 32'h0000_0100);
    drive(1, 0, 32'h0000_0100);
    drive(1, 1, 32'hC000_0000);
    drive(1, 0, 32'hFF20_0000);
    drive(0, 1, 32'hFFFF_0000);
    // sweep every control word, both classes, every window edge (R2..R11)
    for (int cf = 0; cf < 16; cf++) begin
      cfg_write(4'(cf));
      for (int c = 0; c < 2; c++)
        for (int p = 0; p < 20; p++) drive(1, c[0], PTS[p]);
      drive(0, 1, 32'h0000_0000);
    end
    // R12: full-word replace, request in the same cycle as the write
    cfg_write(4'hF);
    drive(1, 1, 32'hC000_1000);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_wdata = 4'h4; req_valid = 1; req_cpu = 1; req_addr = 32'hFF30_0000;
    @(posedge clk); #1;
    cfg_wr = 1'b0; mcfg = 4'h4; just_wrote = 1;
    drive(1, 1, 32'h0000_0000);
    drive(1, 1, 32'hC000_1000);
    drive(1, 1, 32'hFF30_0000);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) cfg_write(4'($urandom_range(0, 15)));
      else if ($urandom_range(0, 1) == 0)
        drive($urandom_range(0, 7) != 0, 1'($urandom_range(0, 1)), $urandom());
      else
        drive($urandom_range(0, 7) != 0, 1'($urandom_range(0, 1)),
              PTS[$urandom_range(0, 19)] + 32'($urandom_range(0, 2)) - 32'd1);
    end
    drive(0, 0, 32'h0);
    @(posedge clk);
    @(negedge clk);
    #1 finish_run();
  end
endmodule